// File: doc/BRIEF.md
# Timed Traffic Intersection Controller

This block drives the lamps of a crossing where a main street (A) meets a side street (B), with a pedestrian crossing. It is a Moore machine: every lamp is decoded from registered state. In normal running it steps through six timed phases: A green, A yellow, B green, B yellow, walk, and a flashing don't-walk phase. Whichever signal is not being served shows its red lamp. One parameter gives the number of clock cycles in one second, so a bench can use a very short second.

A maintenance switch makes all eight lamps blink together at 1 Hz. When the switch drops, the cycle starts again from its first phase with fresh timing. An optional walk-on-demand variant leaves out the pedestrian phases until a walk button has been pressed and released. The request shows on a pending output, is served once at the end of the street sequence, and is then cleared.

Top module: `tlc_intersection`

## Requirements
- R1: Reset puts the lamps in the initial state and restarts timing. The initial state is street A green, street B red, pedestrian stop, and pending 0. Street vectors are bit2 red, bit1 yellow, bit0 green, so A = 3'b001 and B = 3'b100. The pedestrian vector is bit1 walk, bit0 stop, so it reads 2'b01.
- R2: One second is TICKS_PER_SEC cycles. The normal cycle runs A green for 4 s, A yellow for 2 s, B green for 3 s, B yellow for 1 s, walk for 2 s and flashing don't-walk for 4 s, then repeats. It lasts 16 s in all.
- R3: Outside maintenance, at most one signal shows green, yellow or walk, and every other signal shows its red or stop lamp. During flashing don't-walk, both streets show solid red.
- R4: During flashing don't-walk, walk is off. Stop is lit for the first TICKS_PER_SEC/2 cycles of each second of the phase and dark for the rest.
- R5: The clock edge after maintenance input goes to 1 enters maintenance. From then on, all eight lamps are lit for the first TICKS_PER_SEC/2 cycles of each second, counted from entry, and are dark otherwise.
- R6: The clock edge after maintenance input returns to 0 restarts at street A green with fresh phase timing and pending cleared.
- R7: With walk-on-demand enabled and nothing pending, the cycle holds only the four street phases and lasts 10 s.
- R8: With walk-on-demand enabled, a cycle where the walk button is 0 after being 1 sets pending on the next edge. This does not apply in maintenance or on a maintenance-switch edge.
- R9: With walk-on-demand enabled, if pending is set when B yellow ends, the walk and flashing phases follow. Pending clears when the flashing phase ends, unless a new release lands on that same edge.
- R10: With walk-on-demand disabled, the walk button has no effect and pending stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_maint | input | 1 | 1 selects maintenance blinking |
| walk_btn | input | 1 | Walk request button, synchronous |
| street_a | output | 3 | Street A lamps {red, yellow, green} |
| street_b | output | 3 | Street B lamps {red, yellow, green} |
| ped | output | 2 | Pedestrian lamps {walk, stop} |
| walk_pending | output | 1 | Walk request latched and not yet served |

## Verification
Two instances, one fixed-cycle and one walk-on-demand, share the same stimulus. Each is compared every cycle against a timeline model that counts cycles since the last restart. Long idle runs show whether phase lengths and order are right and whether the flash halves line up. Button presses of random length and timing show when a request is latched, served or dropped. Some releases land near the end of B yellow and of the flashing phase, which separates a request served in this cycle from one held to the next. Maintenance windows and resets of random length, some in mid-phase, show whether timing restarts cleanly and whether maintenance blinking stays in step from its own entry.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [2:0] {
        PH_A_GO    = 3'd0,
        PH_A_WARN  = 3'd1,
        PH_B_GO    = 3'd2,
        PH_B_WARN  = 3'd3,
        PH_WALK    = 3'd4,
        PH_WALK_END = 3'd5
    } phase_e;

    typedef struct packed {
        logic red;
        logic amber;
        logic green;
    } street_lamp_t;

    typedef struct packed {
        logic walk;
        logic stop;
    } ped_lamp_t;

    localparam int SEC_W = 3;

    localparam street_lamp_t STREET_STOP = '{red: 1'b1, amber: 1'b0, green: 1'b0};
    localparam street_lamp_t STREET_WARN = '{red: 1'b0, amber: 1'b1, green: 1'b0};
    localparam street_lamp_t STREET_GO   = '{red: 1'b0, amber: 1'b0, green: 1'b1};
    localparam ped_lamp_t    PED_STOP    = '{walk: 1'b0, stop: 1'b1};
    localparam ped_lamp_t    PED_GO      = '{walk: 1'b1, stop: 1'b0};

    // length of each phase in seconds
    function automatic logic [SEC_W-1:0] phase_secs(phase_e p);
        case (p)
            PH_A_GO:     return 3'd4;
            PH_A_WARN:   return 3'd2;
            PH_B_GO:     return 3'd3;
            PH_B_WARN:   return 3'd1;
            PH_WALK:     return 3'd2;
            PH_WALK_END: return 3'd4;
            default:     return 3'd1;
        endcase
    endfunction

    // successor phase; walk_due selects the pedestrian branch after B yellow
    function automatic phase_e phase_after(phase_e p, logic walk_due);
        case (p)
            PH_A_GO:     return PH_A_WARN;
            PH_A_WARN:   return PH_B_GO;
            PH_B_GO:     return PH_B_WARN;
            PH_B_WARN:   return walk_due ? PH_WALK : PH_A_GO;
            PH_WALK:     return PH_WALK_END;
            default:     return PH_A_GO;
        endcase
    endfunction

endpackage

// File: rtl/tlc_sec_timer.sv
module tlc_sec_timer #(
    parameter int TICKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic sec_end,
    output logic flash_on
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);

    logic [CW-1:0] cnt;

    assign sec_end  = (cnt == LAST);
    assign flash_on = (cnt < HALF);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (sec_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tlc_phase_seq.sv
module tlc_phase_seq
    import tlc_pkg::*;
#(
    parameter bit WALK_ON_DEMAND = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   mode_maint,
    input  logic   walk_btn,
    input  logic   sec_end,
    output phase_e phase,
    output logic   maint_q,
    output logic   btn_q,
    output logic   walk_pending,
    output logic   timer_restart
);
    logic [SEC_W-1:0] secs;
    logic             phase_done;
    logic             walk_due;
    logic             mode_edge;
    logic             btn_release;

    assign mode_edge     = (mode_maint != maint_q);
    assign timer_restart = mode_edge;
    assign btn_release   = btn_q & ~walk_btn;
    assign phase_done    = sec_end && (secs == phase_secs(phase) - 3'd1);

    generate
        if (WALK_ON_DEMAND) begin : g_demand
            assign walk_due = walk_pending;
        end else begin : g_fixed
            assign walk_due = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            maint_q <= 1'b0;
            phase   <= PH_A_GO;
            secs    <= '0;
            btn_q   <= 1'b0;
        end else begin
            btn_q <= walk_btn;
            if (mode_edge) begin
                maint_q <= mode_maint;
                phase   <= PH_A_GO;
                secs    <= '0;
            end else if (!maint_q) begin
                if (phase_done) begin
                    phase <= phase_after(phase, walk_due);
                    secs  <= '0;
                end else if (sec_end) begin
                    secs <= secs + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mode_edge || !WALK_ON_DEMAND) begin
            walk_pending <= 1'b0;
        end else if (!maint_q) begin
            if (btn_release) begin
                walk_pending <= 1'b1;
            end else if (phase_done && phase == PH_WALK_END) begin
                walk_pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlc_lamp_map.sv
module tlc_lamp_map
    import tlc_pkg::*;
(
    input  phase_e       phase,
    input  logic         maint,
    input  logic         flash_on,
    output street_lamp_t lamp_a,
    output street_lamp_t lamp_b,
    output ped_lamp_t    lamp_p
);
    always_comb begin
        lamp_a = STREET_STOP;
        lamp_b = STREET_STOP;
        lamp_p = PED_STOP;
        if (maint) begin
            lamp_a = {3{flash_on}};
            lamp_b = {3{flash_on}};
            lamp_p = {2{flash_on}};
        end else begin
            case (phase)
                PH_A_GO:     lamp_a = STREET_GO;
                PH_A_WARN:   lamp_a = STREET_WARN;
                PH_B_GO:     lamp_b = STREET_GO;
                PH_B_WARN:   lamp_b = STREET_WARN;
                PH_WALK:     lamp_p = PED_GO;
                PH_WALK_END: lamp_p = '{walk: 1'b0, stop: flash_on};
                default:     lamp_p = PED_STOP;
            endcase
        end
    end
endmodule

// File: rtl/tlc_intersection.sv
module tlc_intersection
    import tlc_pkg::*;
#(
    parameter int TICKS_PER_SEC  = 50_000_000,
    parameter bit WALK_ON_DEMAND = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_maint,
    input  logic       walk_btn,
    output logic [2:0] street_a,
    output logic [2:0] street_b,
    output logic [1:0] ped,
    output logic       walk_pending
);
    phase_e       phase;
    logic         maint_q;
    logic         btn_q;
    logic         sec_end;
    logic         flash_on;
    logic         timer_restart;
    street_lamp_t lamp_a;
    street_lamp_t lamp_b;
    ped_lamp_t    lamp_p;

    tlc_sec_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (timer_restart),
        .sec_end  (sec_end),
        .flash_on (flash_on)
    );

    tlc_phase_seq #(.WALK_ON_DEMAND(WALK_ON_DEMAND)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .mode_maint    (mode_maint),
        .walk_btn      (walk_btn),
        .sec_end       (sec_end),
        .phase         (phase),
        .maint_q       (maint_q),
        .btn_q         (btn_q),
        .walk_pending  (walk_pending),
        .timer_restart (timer_restart)
    );

    tlc_lamp_map u_map (
        .phase    (phase),
        .maint    (maint_q),
        .flash_on (flash_on),
        .lamp_a   (lamp_a),
        .lamp_b   (lamp_b),
        .lamp_p   (lamp_p)
    );

    assign street_a = lamp_a;
    assign street_b = lamp_b;
    assign ped      = lamp_p;
endmodule

// File: rtl/tlc_intersection_sva.sv
module tlc_intersection_sva #(
    parameter bit WALK_ON_DEMAND = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       mode_maint,
    input logic       walk_btn,
    input logic [2:0] street_a,
    input logic [2:0] street_b,
    input logic [1:0] ped,
    input logic       walk_pending,
    input logic       maint_q,
    input logic       btn_q
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (street_a == 3'b001 && street_b == 3'b100 && ped == 2'b01 && !walk_pending)); // R1

    AST_SINGLE_SERVED: assert property (@(posedge clk) disable iff (rst)
        (!maint_q && street_a != 3'b100) |-> (street_b == 3'b100 && ped == 2'b01)); // R3

    AST_PED_STREETS_RED: assert property (@(posedge clk) disable iff (rst)
        (!maint_q && ped != 2'b01) |-> (street_a == 3'b100 && street_b == 3'b100)); // R3

    AST_ONE_STREET_LAMP: assert property (@(posedge clk) disable iff (rst)
        !maint_q |-> ($countones(street_a) == 1 && $countones(street_b) == 1
                      && $countones(ped) <= 1)); // R3

    AST_MAINT_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        maint_q |-> (street_a == {3{ped[0]}} && street_b == {3{ped[0]}} && ped[1] == ped[0])); // R5

    AST_MAINT_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(maint_q) |-> (street_a == 3'b001 && street_b == 3'b100 && ped == 2'b01
                            && !walk_pending)); // R6

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (WALK_ON_DEMAND && btn_q && !walk_btn && !maint_q && !mode_maint) |=> walk_pending); // R8
endmodule

bind tlc_intersection tlc_intersection_sva #(.WALK_ON_DEMAND(WALK_ON_DEMAND)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .mode_maint   (mode_maint),
    .walk_btn     (walk_btn),
    .street_a     (street_a),
    .street_b     (street_b),
    .ped          (ped),
    .walk_pending (walk_pending),
    .maint_q      (maint_q),
    .btn_q        (btn_q)
);

// File: tb/tlc_intersection_bench.sv
module tlc_intersection_bench;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_maint = 1'b0;
    logic walk_btn = 1'b0;
    logic [2:0] a_n, b_n, a_d, b_d;
    logic [1:0] p_n, p_d;
    logic pend_n, pend_d_o;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tlc_intersection #(.TICKS_PER_SEC(T), .WALK_ON_DEMAND(1'b0)) u_tlc_intersection (
        .clk(clk), .rst(rst), .mode_maint(mode_maint), .walk_btn(walk_btn),
        .street_a(a_n), .street_b(b_n), .ped(p_n), .walk_pending(pend_n));

    tlc_intersection #(.TICKS_PER_SEC(T), .WALK_ON_DEMAND(1'b1)) u_tlc_intersection_walk (
        .clk(clk), .rst(rst), .mode_maint(mode_maint), .walk_btn(walk_btn),
        .street_a(a_d), .street_b(b_d), .ped(p_d), .walk_pending(pend_d_o));

    // timeline model
    int  t_n, pos_d, m;
    bit  pend_m, maint_m, btnp, from_rst, from_maint, valid;

    always @(posedge clk) begin
        bit rel;
        rel   = btnp && !walk_btn;
        valid = 1;
        if (rst) begin
            t_n = 0; pos_d = 0; pend_m = 0; m = 0; maint_m = 0;
            from_rst = 1; from_maint = 0;
        end else if (mode_maint != maint_m) begin
            if (mode_maint) m = 0;
            else begin t_n = 0; pos_d = 0; from_maint = 1; end
            maint_m = mode_maint; pend_m = 0; from_rst = 0;
        end else if (maint_m) begin
            m++; from_rst = 0; from_maint = 0;
        end else begin
            from_rst = 0; from_maint = 0;
            t_n = (t_n + 1) % (16 * T);
            pos_d++;
            if (pos_d == 10 * T && !pend_m) pos_d = 0;
            else if (pos_d == 16 * T) begin pos_d = 0; pend_m = 0; end
            if (rel) pend_m = 1;
        end
        btnp = rst ? 1'b0 : walk_btn;
    end

    function automatic logic [7:0] lights_at(int pos);
        int sec = pos / T;
        logic fl = (pos % T) < (T / 2);
        logic [2:0] a = 3'b100, b = 3'b100;
        logic [1:0] p = 2'b01;
        if (sec < 4) a = 3'b001;
        else if (sec < 6) a = 3'b010;
        else if (sec < 9) b = 3'b001;
        else if (sec < 10) b = 3'b010;
        else if (sec < 12) p = 2'b10;
        else p = {1'b0, fl};
        return {a, b, p};
    endfunction

    function automatic logic excl_ok(logic [7:0] v);
        int act = 0;
        if (v[7:5] != 3'b100) act++;
        if (v[4:2] != 3'b100) act++;
        if (v[1:0] == 2'b10) act++;
        if (act > 1) return 1'b0;
        if (v[1:0] != 2'b01 && (v[7:5] != 3'b100 || v[4:2] != 3'b100)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (valid && !done) begin
            logic [7:0] mexp, en, ed, an, ad;
            string rq_n, rq_d;
            mexp = ((m % T) < (T / 2)) ? 8'hFF : 8'h00;
            an = {a_n, b_n, p_n};
            ad = {a_d, b_d, p_d};
            en = maint_m ? mexp : lights_at(t_n);
            ed = maint_m ? mexp : lights_at(pos_d);
            if (from_rst) begin rq_n = "R1"; rq_d = "R1"; end
            else if (from_maint) begin rq_n = "R6"; rq_d = "R6"; end
            else if (maint_m) begin rq_n = "R5"; rq_d = "R5"; end
            else begin
                rq_n = (t_n >= 12 * T) ? "R4" : "R2";
                rq_d = (pos_d >= 10 * T) ? "R9" : "R7";
            end
            check(rq_n, "fixed lamps", an, en);
            check(rq_d, "demand lamps", ad, ed);
            check("R10", "fixed pending", {7'b0, pend_n}, 8'h00);
            check("R8", "demand pending", {7'b0, pend_d_o}, {7'b0, pend_m});
            if (!maint_m) begin
                check("R3", "fixed exclusive", {7'b0, excl_ok(an)}, 8'h01);
                check("R3", "demand exclusive", {7'b0, excl_ok(ad)}, 8'h01);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst = 1'b0;
        idle(40 * T);                       // R2 R7 idle cycles
        walk_btn = 1'b1; idle(3);           // R8 press and release
        walk_btn = 1'b0; idle(20 * T);      // R9 served
        idle(7 * T + 3);
        walk_btn = 1'b1; idle(1);
        walk_btn = 1'b0; idle(18 * T);
        mode_maint = 1'b1; idle(5 * T + 1); // R5
        walk_btn = 1'b1; idle(2);
        walk_btn = 1'b0; idle(2);
        mode_maint = 1'b0; idle(20 * T);    // R6
        idle(5);
        rst = 1'b1; idle(2);                // R1 mid-phase reset
        rst = 1'b0; idle(18 * T);
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 39) == 0) walk_btn = ~walk_btn;
            if ($urandom_range(0, 699) == 0) mode_maint = ~mode_maint;
            rst = ($urandom_range(0, 1499) == 0);
            idle(1);
        end
        rst = 1'b0; mode_maint = 1'b0; walk_btn = 1'b0;
        idle(20 * T);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule